// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port controlled through a simple word-addressed register interface. Software writes an output value and a per-pin direction; the port drives `pad_out` and `pad_oe` straight from those registers. Every pad level is brought into the clock domain through a two-stage synchronizer. It can then be read back as the pad level, and it feeds per-pin interrupt detection.

Each pin has its own trigger condition: low level, high level, rising edge, falling edge, or either edge. A detected condition latches a sticky status bit, and software clears that bit by writing a one to it. A status bit only raises an interrupt request when the pin is enabled in the interrupt enable register. Pins 0 to 15 share one request output and pins 16 to 31 share the other. The enable register resets to all zeros, so no interrupt request is raised after reset.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register reads 0, `pad_out` and `pad_oe` are 0 and both interrupt outputs are low.
- R2: The output value register sits at word 0 (byte offset 0x00) and the direction register at word 1 (0x04). Both read back what was last written. One cycle after a write, `pad_out` equals the output value register and `pad_oe` equals the direction register; a direction bit of 1 makes that pin an output.
- R3: Word 2 (0x08) is read-only and returns each pin's level as sampled through the two-flop synchronizer, for output pins too. A change on `pad_in` becomes visible there after two clock edges.
- R4: The trigger code per pin is 2 bits: 0 is low level, 1 is high level, 2 is rising edge and 3 is falling edge. An edge is a difference between the current and the previous synchronized sample.
- R5: Trigger codes for pins 0 to 15 live in word 3 (0x0C), pin n at bits [2n+1:2n]. Codes for pins 16 to 31 live in word 4 (0x10), pin n at bits [2(n-16)+1:2(n-16)].
- R6: A 1 in the either-edge register, word 7 (0x1C), makes that pin's status set on both edges, and the pin's 2-bit trigger code is ignored.
- R7: The status register, word 6 (0x18), is write-one-to-clear: a written 1 clears that bit and a written 0 leaves it unchanged. If a clear and a new event for the same pin fall in the same cycle, the event wins.
- R8: A level trigger sets the status bit on every cycle that the level holds, so clearing the bit while the level persists has no lasting effect.
- R9: The interrupt enable register is word 5 (0x14). `irq_lo` is the OR of (status AND enable) over pins 0 to 15, and `irq_hi` is the same OR over pins 16 to 31.
- R10: Byte address bits [1:0] are ignored. Reads of word 8 and above return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Pad levels as seen at the pins |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin |
| irq_lo | output | 1 | Interrupt request for pins 0 to 15 |
| irq_hi | output | 1 | Interrupt request for pins 16 to 31 |

## Verification
The assertions assume that `pad_in` is sampled only at rising edges and that `bus_addr`, `bus_we` and `bus_wdata` are stable around each edge. The pad-status property assumes at least two edges have passed since reset was released, so that the synchronizer holds real samples. The bench changes all inputs on the falling edge, holds `pad_in` low through reset, and loops outputs back onto their pins, so pad levels only ever change between edges. Random traffic also covers the ignored address bits and unmapped words.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Word indices within the register window (byte address >> 2)
    localparam logic [2:0] W_DOUT  = 3'd0;
    localparam logic [2:0] W_DIR   = 3'd1;
    localparam logic [2:0] W_PAD   = 3'd2;
    localparam logic [2:0] W_CFG_A = 3'd3;
    localparam logic [2:0] W_CFG_B = 3'd4;
    localparam logic [2:0] W_MASK  = 3'd5;
    localparam logic [2:0] W_STAT  = 3'd6;
    localparam logic [2:0] W_BOTH  = 3'd7;
    localparam int         NUM_WORDS = 8;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_FALL = 2'd3
    } trig_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_port_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic [PINS-1:0] cur,
    input  logic [PINS-1:0] prev,
    input  logic [PINS-1:0] cfg_a,
    input  logic [PINS-1:0] cfg_b,
    input  logic [PINS-1:0] both,
    output logic [PINS-1:0] evt
);
    localparam int HALF = PINS / 2;

    generate
        for (genvar p = 0; p < PINS; p++) begin : g_pin
            logic [1:0] code;
            logic       rise, fall;
            if (p < HALF) begin : g_a
                assign code = cfg_a[2*p +: 2];
            end else begin : g_b
                assign code = cfg_b[2*(p-HALF) +: 2];
            end
            assign rise = cur[p] & ~prev[p];
            assign fall = ~cur[p] & prev[p];
            always_comb begin
                if (both[p]) begin
                    evt[p] = rise | fall;
                end else begin
                    unique case (trig_e'(code))
                        TRIG_LOW:  evt[p] = ~cur[p];
                        TRIG_HIGH: evt[p] = cur[p];
                        TRIG_RISE: evt[p] = rise;
                        TRIG_FALL: evt[p] = fall;
                        default:   evt[p] = 1'b0;
                    endcase
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
    parameter int PINS = 32
) (
    input  logic [PINS-1:0] stat,
    input  logic [PINS-1:0] mask,
    output logic            irq_lo,
    output logic            irq_hi
);
    localparam int HALF = PINS / 2;

    logic [PINS-1:0] pend;
    assign pend = stat & mask;

    generate
        for (genvar h = 0; h < 2; h++) begin : g_half
            logic any;
            assign any = |pend[h*HALF +: HALF];
            if (h == 0) begin : g_lo
                assign irq_lo = any;
            end else begin : g_hi
                assign irq_hi = any;
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int PINS        = 32,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic              irq_lo,
    output logic              irq_hi
);
    typedef struct packed {
        logic [PINS-1:0] dout;
        logic [PINS-1:0] dir;
        logic [PINS-1:0] cfg_a;
        logic [PINS-1:0] cfg_b;
        logic [PINS-1:0] mask;
        logic [PINS-1:0] stat;
        logic [PINS-1:0] both;
        logic [PINS-1:0] prev;
    } port_state_t;

    port_state_t      r_d, r_q;
    logic [PINS-1:0]  smp;
    logic [PINS-1:0]  evt;
    logic [ADDR_W-1:0] word_full;
    logic             hit;
    logic [2:0]       idx;
    logic [PINS-1:0]  mask_q;

    assign word_full = bus_addr >> 2;
    assign hit       = word_full < ADDR_W'(NUM_WORDS);
    assign idx       = word_full[2:0];
    assign mask_q    = r_q.mask;

    gpio_pin_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (smp)
    );

    gpio_trig_detect #(.PINS(PINS)) u_detect (
        .cur   (smp),
        .prev  (r_q.prev),
        .cfg_a (r_q.cfg_a),
        .cfg_b (r_q.cfg_b),
        .both  (r_q.both),
        .evt   (evt)
    );

    gpio_irq_merge #(.PINS(PINS)) u_irq (
        .stat   (r_q.stat),
        .mask   (r_q.mask),
        .irq_lo (irq_lo),
        .irq_hi (irq_hi)
    );

    // Next-state computation
    always_comb begin
        logic [PINS-1:0] clr_d;
        r_d      = r_q;
        r_d.prev = smp;
        clr_d    = '0;
        if (bus_we && hit) begin
            unique case (idx)
                W_DOUT:  r_d.dout  = bus_wdata;
                W_DIR:   r_d.dir   = bus_wdata;
                W_CFG_A: r_d.cfg_a = bus_wdata;
                W_CFG_B: r_d.cfg_b = bus_wdata;
                W_MASK:  r_d.mask  = bus_wdata;
                W_STAT:  clr_d     = bus_wdata;
                W_BOTH:  r_d.both  = bus_wdata;
                default: ;
            endcase
        end
        r_d.stat = (r_q.stat & ~clr_d) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            unique case (idx)
                W_DOUT:  bus_rdata = r_q.dout;
                W_DIR:   bus_rdata = r_q.dir;
                W_PAD:   bus_rdata = smp;
                W_CFG_A: bus_rdata = r_q.cfg_a;
                W_CFG_B: bus_rdata = r_q.cfg_b;
                W_MASK:  bus_rdata = r_q.mask;
                W_STAT:  bus_rdata = r_q.stat;
                W_BOTH:  bus_rdata = r_q.both;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign pad_out = r_q.dout;
    assign pad_oe  = r_q.dir;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
    parameter int PINS   = 32,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PINS-1:0]   bus_wdata,
    input logic [PINS-1:0]   bus_rdata,
    input logic [PINS-1:0]   pad_in,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_oe,
    input logic              irq_lo,
    input logic              irq_hi,
    input logic [PINS-1:0]   mask_q
);
    localparam int HALF = PINS / 2;

    logic [ADDR_W-1:0] word;
    logic [1:0]        age_q;
    assign word = bus_addr >> 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    assert_dout_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && word == ADDR_W'(0)) |=> pad_out == $past(bus_wdata));

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && word == ADDR_W'(1)) |=> pad_oe == $past(bus_wdata));

    assert_pad_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && word == ADDR_W'(2)) |-> bus_rdata == $past(pad_in, 2));

    assert_mask_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && word == ADDR_W'(5) && bus_wdata == '0) |=> (!irq_lo && !irq_hi));

    assert_irq_lo_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> mask_q[HALF-1:0] != '0);

    assert_irq_hi_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> mask_q[PINS-1:HALF] != '0);

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (word >= ADDR_W'(8)) |-> bus_rdata == '0);
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq_lo    (irq_lo),
    .irq_hi    (irq_hi),
    .mask_q    (mask_q)
);

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in;
    logic [31:0] pad_out, pad_oe;
    logic        irq_lo, irq_hi;
    logic [31:0] ext = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // Pins driven by the port loop back; the rest follow the external driver
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    // Behavioural reference state
    logic [31:0] m_dout, m_dir, m_ca, m_cb, m_mask, m_stat, m_both, m_s1, m_s2, m_prev;

    function automatic logic [31:0] ref_events(input logic [31:0] cur, input logic [31:0] old,
                                               input logic [31:0] ca, input logic [31:0] cb,
                                               input logic [31:0] bo);
        logic [31:0] e = '0;
        for (int p = 0; p < 32; p++) begin
            int code = (p < 16) ? int'((ca >> (2*p)) & 3) : int'((cb >> (2*(p-16))) & 3);
            if (bo[p])          e[p] = cur[p] != old[p];
            else if (code == 0) e[p] = !cur[p];
            else if (code == 1) e[p] = cur[p];
            else if (code == 2) e[p] = cur[p] && !old[p];
            else                e[p] = !cur[p] && old[p];
        end
        return e;
    endfunction

    function automatic logic [31:0] ref_read(input logic [5:0] a);
        case (int'(a >> 2))
            0: return m_dout;
            1: return m_dir;
            2: return m_s2;
            3: return m_ca;
            4: return m_cb;
            5: return m_mask;
            6: return m_stat;
            7: return m_both;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [5:0] a);
        case (int'(a >> 2))
            0, 1: return "R2";
            2: return "R3";
            3, 4: return "R5";
            5: return "R9";
            6: return "R7";
            7: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Model update on each edge, then comparison once outputs settle
    always @(posedge clk) begin
        if (!rst_n) begin
            {m_dout, m_dir, m_ca, m_cb, m_mask, m_stat, m_both, m_s1, m_s2, m_prev} = '0;
        end else begin
            logic [31:0] lvl, ev, clr;
            lvl = (m_dir & m_dout) | (~m_dir & ext);
            ev  = ref_events(m_s2, m_prev, m_ca, m_cb, m_both);
            clr = '0;
            if (bus_we) begin
                case (int'(bus_addr >> 2))
                    0: m_dout = bus_wdata;
                    1: m_dir  = bus_wdata;
                    3: m_ca   = bus_wdata;
                    4: m_cb   = bus_wdata;
                    5: m_mask = bus_wdata;
                    6: clr    = bus_wdata;
                    7: m_both = bus_wdata;
                    default: ;
                endcase
            end
            m_stat = (m_stat & ~clr) | ev;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = lvl;
        end
        #2;
        if (rst_n && !done) begin
            check(pad_out === m_dout, "R2 pad_out", pad_out, m_dout);
            check(pad_oe === m_dir, "R2 pad_oe", pad_oe, m_dir);
            check(irq_lo === |(m_stat[15:0] & m_mask[15:0]), "R9 irq_lo", 32'(irq_lo),
                  32'(|(m_stat[15:0] & m_mask[15:0])));
            check(irq_hi === |(m_stat[31:16] & m_mask[31:16]), "R9 irq_hi", 32'(irq_hi),
                  32'(|(m_stat[31:16] & m_mask[31:16])));
            check(bus_rdata === ref_read(bus_addr), read_tag(bus_addr), bus_rdata, ref_read(bus_addr));
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_bits(input logic [5:0] a, input logic [31:0] sel,
                           input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check((bus_rdata & sel) === exp, tag, bus_rdata & sel, exp);
    endtask

    initial begin
        logic [31:0] lfsr = 32'h1ACE_B00C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd_bits(6'h04, 32'hFFFF_FFFF, 32'h0, "R1 dir");
        rd_bits(6'h14, 32'hFFFF_FFFF, 32'h0, "R1 mask");
        rd_bits(6'h1C, 32'hFFFF_FFFF, 32'h0, "R1 both");
        check(pad_oe === 32'h0 && pad_out === 32'h0, "R1 pads", pad_oe, 32'h0);
        check(!irq_lo && !irq_hi, "R1 irq", {30'h0, irq_hi, irq_lo}, 32'h0);
        // R10: unmapped word
        rd_bits(6'h24, 32'hFFFF_FFFF, 32'h0, "R10 unmapped");
        // R4: rising on pin 0; pins 16-31 level high, idle low
        wr(6'h0C, 32'hAAAA_AAAA);
        wr(6'h10, 32'h5555_5555);
        idle(4);
        wr(6'h18, 32'hFFFF_FFFF);
        idle(2);
        rd_bits(6'h18, 32'hFFFF_FFFF, 32'h0, "R4 quiet");
        ext[0] = 1'b1;
        idle(4);
        rd_bits(6'h18, 32'hFFFF_FFFF, 32'h1, "R4 rise");
        // R7: write 0 leaves, write 1 clears
        wr(6'h18, 32'h0);
        rd_bits(6'h18, 32'h1, 32'h1, "R7 zero keeps");
        wr(6'h18, 32'h1);
        rd_bits(6'h18, 32'h1, 32'h0, "R7 one clears");
        // R4: falling on pin 1 (bits 3:2 = 3)
        wr(6'h0C, 32'hAAAA_AAAE);
        ext[1] = 1'b1;
        idle(4);
        rd_bits(6'h18, 32'h2, 32'h0, "R4 fall ignores rise");
        ext[1] = 1'b0;
        idle(4);
        rd_bits(6'h18, 32'h2, 32'h2, "R4 fall");
        // R6: either-edge on pin 2 overrides rising code
        wr(6'h1C, 32'h4);
        ext[2] = 1'b1;
        idle(4);
        wr(6'h18, 32'h4);
        idle(1);
        rd_bits(6'h18, 32'h4, 32'h0, "R6 cleared");
        ext[2] = 1'b0;
        idle(4);
        rd_bits(6'h18, 32'h4, 32'h4, "R6 falling edge sets");
        // R8: level high on pin 16 re-sets after clear
        ext[16] = 1'b1;
        idle(4);
        wr(6'h18, 32'h0001_0000);
        idle(1);
        rd_bits(6'h18, 32'h0001_0000, 32'h0001_0000, "R8 level persists");
        // R5: pin 17 rising via word 4 bits 3:2
        wr(6'h10, 32'h5555_5559);
        wr(6'h18, 32'h0002_0000);
        idle(1);
        ext[17] = 1'b1;
        idle(4);
        rd_bits(6'h18, 32'h0002_0000, 32'h0002_0000, "R5 pin17 rise");
        // R9: enable gating
        wr(6'h18, 32'hFFFF);
        idle(1);
        wr(6'h14, 32'h0001_0000);
        idle(1);
        check(irq_hi === 1'b1 && irq_lo === 1'b0, "R9 hi only", {30'h0, irq_hi, irq_lo}, 32'h2);
        // R2/R3: outputs loop back into pad status
        ext[15:8] = 8'h5A;
        wr(6'h04, 32'h0000_FF00);
        wr(6'h00, 32'h0000_A500);
        idle(3);
        check(pad_out === 32'h0000_A500 && pad_oe === 32'h0000_FF00, "R2 drive", pad_out, 32'h0000_A500);
        rd_bits(6'h08, 32'h0000_FF00, 32'h0000_A500, "R3 output pad level");
        // R10: low address bits ignored
        wr(6'h17, 32'h0000_0003);
        rd_bits(6'h14, 32'hFFFF_FFFF, 32'h0000_0003, "R10 low bits");
        // Random traffic, model compared every cycle
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            bus_we   = lfsr[3] & lfsr[7];
            bus_addr = {lfsr[12:9], lfsr[14:13]};
            bus_wdata = lfsr ^ {lfsr[15:0], lfsr[31:16]};
            if (lfsr[20]) ext = ext ^ (32'h1 << lfsr[28:24]);
        end
        @(negedge clk);
        bus_we = 1'b0;
        idle(4);
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule